// File: doc/BRIEF.md
# Multi-encoding signed adder/subtractor

This block adds or subtracts two signed W-bit operands. A select input picks how the operand bits encode a number: two's complement, one's complement or sign-and-magnitude. The result comes back in the same encoding, together with an overflow flag. The block forms the negated subtrahend itself. In one's complement it folds the carry out of the sign position back into the least significant bit. In sign-and-magnitude it compares the magnitudes, subtracts the smaller from the larger and takes the sign of the larger operand.

Inputs are sampled on a rising clock edge. The result and the flag are registered, so they appear one cycle later and hold until the next edge. A new operation can start on every cycle. The width W is a parameter and defaults to 8.

Top module: `msum_addsub`

## Requirements
- R1: While rst_n is low, sum and ovf are 0.
- R2: The sum and ovf that follow from the inputs sampled at one rising edge appear right after that edge and stay stable until the next edge.
- R3: With enc = 2'b00 (two's complement), sum equals (A + B) mod 2^W for add (sub = 0) and (A - B) mod 2^W for subtract (sub = 1). A carry out of the top bit is discarded.
- R4: With enc = 2'b00, ovf is 1 exactly when the true signed result lies outside -2^(W-1) .. 2^(W-1)-1.
- R5: With enc = 2'b01 (one's complement), a value with a 0 in bit W-1 is read as plain binary, and a value with a 1 in bit W-1 is the negative of its bitwise inverse. For subtract, B is inverted bit by bit before the add. Any carry out of bit W-1 is added back into bit 0. A result that does not overflow has the true value. Zero is returned as all zeros only when both effective operands are all zeros; any other zero result is all ones.
- R6: With enc = 2'b01, ovf is 1 exactly when the true result magnitude exceeds 2^(W-1)-1.
- R7: With enc = 2'b10 (sign-and-magnitude), bit W-1 is the sign (1 = negative) and bits W-2..0 are the magnitude. Subtract flips the sign of B. When the signs match, the magnitudes are added and the common sign is kept. When they differ, the smaller magnitude is taken from the larger and the result takes the sign of the larger one. A result that does not overflow has the true value.
- R8: With enc = 2'b10, a zero magnitude result always has its sign bit cleared (+0).
- R9: With enc = 2'b10, ovf is 1 exactly when the signs match and the magnitude sum carries out of W-1 bits. Operands of differing sign never overflow.
- R10: enc = 2'b11 behaves exactly like two's complement (enc = 2'b00).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_a | input | W | Operand A |
| op_b | input | W | Operand B |
| sub | input | 1 | 0 = A + B, 1 = A - B |
| enc | input | 2 | Encoding: 00 two's, 01 one's, 10 sign-magnitude, 11 two's |
| sum | output | W | Registered result in the selected encoding |
| ovf | output | 1 | Registered overflow flag |

## Verification
The bench aims at the edges of the range in each encoding. In two's complement it subtracts the most negative value; a design that negated B as a separate W-bit step would miss that overflow. In one's complement it uses sums that produce a carry out of the sign bit, and adds with negative zero; without the end-around carry the result would be off by one, and a wrong zero rule would return the other zero pattern. In sign-and-magnitude it uses equal magnitudes of opposite sign and operands of negative zero. These cases catch a design that leaves -0 in the result, takes the sign from the wrong operand, or raises overflow on a difference. Several hundred random operations in all four encodings then compare results against an integer model.

// File: rtl/msum_addsub.sv
module msum_addsub #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub,
  input  logic [1:0]   enc,
  output logic [W-1:0] sum,
  output logic         ovf
);
  localparam int M = W - 1;

  // shared inverted subtrahend for the complement encodings
  logic [W-1:0] binv;
  assign binv = op_b ^ {W{sub}};

  // two's complement
  logic [W:0]   t2_full;
  logic [M:0]   t2_low;
  logic [W-1:0] res2;
  logic         ov2;
  assign t2_full = {1'b0, op_a} + {1'b0, binv} + {{W{1'b0}}, sub};
  assign t2_low  = {1'b0, op_a[M-1:0]} + {1'b0, binv[M-1:0]} + {{M{1'b0}}, sub};
  assign res2    = t2_full[M:0];
  assign ov2     = t2_full[W] ^ t2_low[M];

  // one's complement with end-around carry
  logic [W:0]   t1_full;
  logic [W-1:0] res1;
  logic         ov1;
  assign t1_full = {1'b0, op_a} + {1'b0, binv};
  assign res1    = t1_full[M:0] + {{M{1'b0}}, t1_full[W]};
  assign ov1     = (op_a[M] == binv[M]) && (res1[M] != op_a[M]);

  // sign and magnitude
  logic         sa, sb, same, a_ge;
  logic [M-1:0] ma, mb, mdiff, mres;
  logic [M:0]   msum;
  logic         sres, ovs;
  assign sa    = op_a[M];
  assign sb    = op_b[M] ^ sub;
  assign ma    = op_a[M-1:0];
  assign mb    = op_b[M-1:0];
  assign same  = (sa == sb);
  assign a_ge  = (ma >= mb);
  assign msum  = {1'b0, ma} + {1'b0, mb};
  assign mdiff = a_ge ? (ma - mb) : (mb - ma);
  assign mres  = same ? msum[M-1:0] : mdiff;
  assign sres  = (mres == '0) ? 1'b0 : ((same || a_ge) ? sa : sb);
  assign ovs   = same && msum[M];

  logic [W-1:0] nxt_sum;
  logic         nxt_ovf;
  always_comb begin
    case (enc)
      2'b01:   begin nxt_sum = res1;         nxt_ovf = ov1; end
      2'b10:   begin nxt_sum = {sres, mres}; nxt_ovf = ovs; end
      default: begin nxt_sum = res2;         nxt_ovf = ov2; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum <= '0;
      ovf <= 1'b0;
    end else begin
      sum <= nxt_sum;
      ovf <= nxt_ovf;
    end
  end
endmodule

// File: rtl/msum_addsub_chk.sv
module msum_addsub_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         sub,
  input logic [1:0]   enc,
  input logic [W-1:0] sum,
  input logic         ovf
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (sum == '0 && !ovf));

  assert_twos_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (enc == 2'b00 && !sub && op_a == '0) |=> (sum == $past(op_b) && !ovf));

  assert_twos_mixed_sign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enc == 2'b00 && !sub && op_a[W-1] != op_b[W-1]) |=> !ovf);

  assert_ones_self_sub_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (enc == 2'b01 && sub && op_a == op_b) |=> (sum == '1 && !ovf));

  assert_sm_self_sub_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enc == 2'b10 && sub && op_a == op_b) |=> (sum == '0 && !ovf));

  assert_sm_no_neg_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (enc == 2'b10) |=> (sum[W-2:0] != '0 || !sum[W-1]));

  assert_sm_diff_sign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enc == 2'b10 && (op_a[W-1] != (op_b[W-1] ^ sub))) |=> !ovf);

  assert_alias_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (enc == 2'b11 && sub && op_a == op_b) |=> (sum == '0 && !ovf));
endmodule

bind msum_addsub msum_addsub_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
  .sub(sub), .enc(enc), .sum(sum), .ovf(ovf)
);

// File: tb/tb_msum_addsub.sv
module tb_msum_addsub;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;
  localparam int LIM = (1 << (W - 1)) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic         sub = 1'b0;
  logic [1:0]   enc = 2'b00;
  logic [W-1:0] sum;
  logic         ovf;

  msum_addsub #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b),
    .sub(sub), .enc(enc), .sum(sum), .ovf(ovf)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  typedef struct {
    logic [W-1:0] sum;
    logic         ovf;
    bit           chk_sum;
    int           due;
    string        req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   errors = 0;
  int   checks = 0;
  bit   finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int as_int(input logic [W-1:0] x, input logic [1:0] e);
    logic [W-1:0] inv;
    inv = ~x;
    if (e == 2'b01) return x[W-1] ? -int'(inv) : int'(x);
    if (e == 2'b10) return x[W-1] ? -int'(x[W-2:0]) : int'(x[W-2:0]);
    return x[W-1] ? int'(x) - (1 << W) : int'(x);
  endfunction

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic s, input logic [1:0] e);
    exp_t it;
    logic [W-1:0] be, t;
    int v, mag;
    @(negedge clk);
    #1;
    op_a = a; op_b = b; sub = s; enc = e;
    it.due = cyc + 1;
    it.chk_sum = 1'b1;
    if (e == 2'b01) begin
      be = s ? ~b : b;
      v = as_int(a, e) + as_int(be, e);
      it.req = "R5";
      it.ovf = (v > LIM) || (v < -LIM);
      it.chk_sum = !it.ovf;
      if (it.ovf) it.req = "R6";
      if (v == 0) it.sum = (a == '0 && be == '0) ? '0 : '1;
      else if (v > 0) it.sum = W'(v);
      else begin t = W'(-v); it.sum = ~t; end
    end else if (e == 2'b10) begin
      be = {b[W-1] ^ s, b[W-2:0]};
      v = as_int(a, e) + as_int(be, e);
      it.req = (v == 0) ? "R8" : "R7";
      it.ovf = (v > LIM) || (v < -LIM);
      it.chk_sum = !it.ovf;
      if (it.ovf) it.req = "R9";
      mag = (v < 0) ? -v : v;
      it.sum = {(v < 0), (W-1)'(mag)};
    end else begin
      v = s ? as_int(a, e) - as_int(b, e) : as_int(a, e) + as_int(b, e);
      it.sum = W'(v);
      it.ovf = (v > LIM) || (v < -LIM - 1);
      it.req = (e == 2'b11) ? "R10" : (it.ovf ? "R4" : "R3");
    end
    q.push_back(it);
  endtask

  // monitor: result is due one edge after the inputs were sampled (R2)
  always @(negedge clk) begin
    if (rst_n && q.size() > 0 && q[0].due == cyc) begin
      exp_t it;
      it = q.pop_front();
      checks++;
      if ((it.chk_sum && sum !== it.sum) || ovf !== it.ovf) begin
        errors++;
        $display("FAIL %s (R2 timing): sum=%h exp=%h ovf=%b exp=%b",
                 it.req, sum, it.sum, ovf, it.ovf);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, act=hung exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (sum !== '0 || ovf !== 1'b0) begin
      errors++;
      $display("FAIL R1: sum=%h exp=00 ovf=%b exp=0", sum, ovf);
    end
    rst_n = 1'b1;

    // two's complement (R3, R4)
    send(8'h03, 8'h05, 0, 2'b00);
    send(8'h02, 8'hFB, 0, 2'b00);
    send(8'h04, 8'h02, 1, 2'b00);
    send(8'h7F, 8'h01, 0, 2'b00);
    send(8'h80, 8'h01, 1, 2'b00);
    send(8'h00, 8'h80, 1, 2'b00);
    send(8'h80, 8'h80, 1, 2'b00);
    send(8'h80, 8'h80, 0, 2'b00);
    send(8'hFC, 8'hFB, 0, 2'b00);
    // alias code (R10)
    send(8'h7F, 8'h7F, 0, 2'b11);
    send(8'h10, 8'h20, 1, 2'b11);
    // one's complement (R5, R6)
    send(8'hFC, 8'hFB, 0, 2'b01);
    send(8'hFC, 8'hFB, 1, 2'b01);
    send(8'h05, 8'h05, 1, 2'b01);
    send(8'h00, 8'h00, 0, 2'b01);
    send(8'hFF, 8'hFF, 0, 2'b01);
    send(8'h80, 8'hFF, 0, 2'b01);
    send(8'h7F, 8'h01, 0, 2'b01);
    send(8'h80, 8'h01, 1, 2'b01);
    // sign and magnitude (R7, R8, R9)
    send(8'h05, 8'h83, 0, 2'b10);
    send(8'h03, 8'h85, 0, 2'b10);
    send(8'h85, 8'h83, 0, 2'b10);
    send(8'h85, 8'h85, 1, 2'b10);
    send(8'h80, 8'h00, 0, 2'b10);
    send(8'h80, 8'h05, 0, 2'b10);
    send(8'h7F, 8'h01, 0, 2'b10);
    send(8'hFF, 8'hFF, 0, 2'b10);
    send(8'h40, 8'hC0, 1, 2'b10);
    send(8'h7F, 8'hFF, 0, 2'b10);

    for (int i = 0; i < 400; i++)
      send(W'($urandom), W'($urandom), 1'($urandom), 2'($urandom));

    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      errors++;
      checks++;
      $display("FAIL R2: pending=%0d exp=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule